// File: doc/BRIEF.md
# I2C Wiper Position Register Slave

This block is a serial-bus slave that gives a host read and write access to one 8-bit wiper position code. The bus lines SCL and SDA are oversampled by a faster system clock through two-flop synchronizers. Every bus event is recognised on the synchronized copies: START, repeated START, STOP, and both SCL edges. The block drives SDA only through an open-drain enable (`sda_oe_o` high pulls the line low). It never holds SCL low.

A write is made of a START, the device identifier with the direction bit clear, the register address 00h, one data byte and a STOP. The data byte is committed to the wiper register on the SCL falling edge that ends its least significant bit, before the acknowledge clock. A one-cycle strobe marks the update. A read begins the same way up to the address byte. It continues with a repeated START and the identifier with the direction bit set. The slave then sends the wiper code MSB first, and sends it again after every byte the master acknowledges.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After reset the wiper code is 80h, `sda_oe_o` is low (SDA released) and the update strobe is low.
- R2: A write of START, byte 50h (identifier 0101000, direction bit 0), byte 00h, data byte D, STOP is acknowledged on all three ninth clocks. It sets the wiper code to D and raises `wiper_upd_o` for exactly one system clock cycle per commit.
- R3: The new wiper code is already visible after the SCL falling edge of the data LSB, before SCL rises for the acknowledge clock.
- R4: An identifier byte whose upper seven bits differ from 0101000 is not acknowledged. SDA stays released for the rest of that transfer, and the wiper code is unchanged.
- R5: An address byte other than 00h is not acknowledged. The byte that follows it is neither acknowledged nor committed.
- R6: START, 50h, 00h, repeated START, 51h is acknowledged on all three bytes. The slave then shifts out the current wiper code MSB first, with bits changing only after SCL falls.
- R7: During a read the wiper code is sent again for every byte the master acknowledges. After a master NACK and a STOP, SDA is released.
- R8: A read identifier (51h) that is not preceded by an accepted address byte in the same transfer is not acknowledged.
- R9: SCL clocking with no preceding START is ignored: no acknowledge and no change to the wiper code.
- R10: `sda_oe_o` changes only in a cycle after the synchronized SCL was low.
- R11: A STOP in the middle of a data byte abandons the write: no commit and no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | Open-drain enable; high pulls SDA low |
| wiper_o | output | 8 | Current wiper position code |
| wiper_upd_o | output | 1 | One-cycle strobe when a new code is committed |

## Verification
The register commit and the start of the acknowledge are decided on the same SCL falling edge, so the strobe and the rising `sda_oe_o` appear in the same system clock cycle. Every write provokes this. The bench reads the wiper code in the SCL-low gap before the ninth clock, then samples the line during that clock's high phase to judge the acknowledge separately. A scoreboard queue holds the expected committed codes. Aborted and rejected writes leave nothing in the queue, so a stray strobe is reported at once.

// File: rtl/wip_pkg.sv
package wip_pkg;

    localparam int WORD_W = 8;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK,
        PH_WAIT
    } phase_t;

    typedef enum logic [1:0] {
        BY_ID,
        BY_ADDR,
        BY_DATA
    } byte_kind_t;

    typedef enum logic [1:0] {
        AF_RX,
        AF_TX,
        AF_END
    } after_t;

    typedef struct packed {
        phase_t            phase;
        byte_kind_t        kind;
        byte_kind_t        next_kind;
        after_t            after;
        logic [CNT_W-1:0]  bitcnt;
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] wiper;
        logic              addr_ok;
        logic              mack;
        logic              oe;
        logic              upd;
    } ctl_t;

endpackage

// File: rtl/wip_sync.sv
module wip_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= IDLE_VAL;
                else        chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{IDLE_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wip_bus_cond.sv
module wip_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    assign start_o = scl_prev_q & scl_s & sda_prev_q & ~sda_s;
    assign stop_o  = scl_prev_q & scl_s & ~sda_prev_q & sda_s;
    assign rise_o  = ~scl_prev_q & scl_s;
    assign fall_o  = scl_prev_q & ~scl_s;
endmodule

// File: rtl/wip_proto.sv
module wip_proto
    import wip_pkg::*;
#(
    parameter logic [6:0]        DEV_ID     = 7'b0101000,
    parameter logic [WORD_W-1:0] REG_ADDR   = 8'h00,
    parameter logic [WORD_W-1:0] RESET_CODE = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [WORD_W-1:0] wiper_o,
    output logic              upd_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.upd = 1'b0;
        if (start_i) begin
            ctl_d.phase  = PH_RX;
            ctl_d.kind   = BY_ID;
            ctl_d.bitcnt = '0;
            ctl_d.oe     = 1'b0;
        end else if (stop_i) begin
            ctl_d.phase   = PH_IDLE;
            ctl_d.oe      = 1'b0;
            ctl_d.addr_ok = 1'b0;
        end else begin
            case (ctl_q.phase)
                PH_RX: begin
                    if (rise_i && ctl_q.bitcnt != FULL) begin
                        ctl_d.shreg  = {ctl_q.shreg[WORD_W-2:0], sda_i};
                        ctl_d.bitcnt = ctl_q.bitcnt + 1'b1;
                    end else if (fall_i && ctl_q.bitcnt == FULL) begin
                        ctl_d.bitcnt = '0;
                        ctl_d.oe     = 1'b0;
                        ctl_d.phase  = PH_WAIT;
                        case (ctl_q.kind)
                            BY_ID: begin
                                if (ctl_q.shreg[WORD_W-1:1] == DEV_ID) begin
                                    if (!ctl_q.shreg[0]) begin
                                        ctl_d.phase     = PH_ACK;
                                        ctl_d.oe        = 1'b1;
                                        ctl_d.after     = AF_RX;
                                        ctl_d.next_kind = BY_ADDR;
                                    end else if (ctl_q.addr_ok) begin
                                        ctl_d.phase = PH_ACK;
                                        ctl_d.oe    = 1'b1;
                                        ctl_d.after = AF_TX;
                                    end
                                end
                            end
                            BY_ADDR: begin
                                if (ctl_q.shreg == REG_ADDR) begin
                                    ctl_d.addr_ok   = 1'b1;
                                    ctl_d.phase     = PH_ACK;
                                    ctl_d.oe        = 1'b1;
                                    ctl_d.after     = AF_RX;
                                    ctl_d.next_kind = BY_DATA;
                                end
                            end
                            BY_DATA: begin
                                if (ctl_q.addr_ok) begin
                                    ctl_d.wiper = ctl_q.shreg;
                                    ctl_d.upd   = 1'b1;
                                    ctl_d.phase = PH_ACK;
                                    ctl_d.oe    = 1'b1;
                                    ctl_d.after = AF_END;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                PH_ACK: begin
                    if (fall_i) begin
                        ctl_d.bitcnt = '0;
                        case (ctl_q.after)
                            AF_RX: begin
                                ctl_d.phase = PH_RX;
                                ctl_d.kind  = ctl_q.next_kind;
                                ctl_d.oe    = 1'b0;
                            end
                            AF_TX: begin
                                ctl_d.phase = PH_TX;
                                ctl_d.shreg = ctl_q.wiper;
                                ctl_d.oe    = ~ctl_q.wiper[WORD_W-1];
                            end
                            default: begin
                                ctl_d.phase = PH_WAIT;
                                ctl_d.oe    = 1'b0;
                            end
                        endcase
                    end
                end
                PH_TX: begin
                    if (fall_i) begin
                        if (ctl_q.bitcnt == LAST) begin
                            ctl_d.oe    = 1'b0;
                            ctl_d.phase = PH_MACK;
                        end else begin
                            ctl_d.shreg  = {ctl_q.shreg[WORD_W-2:0], 1'b0};
                            ctl_d.oe     = ~ctl_q.shreg[WORD_W-2];
                            ctl_d.bitcnt = ctl_q.bitcnt + 1'b1;
                        end
                    end
                end
                PH_MACK: begin
                    if (rise_i) begin
                        ctl_d.mack = ~sda_i;
                    end else if (fall_i) begin
                        if (ctl_q.mack) begin
                            ctl_d.phase  = PH_TX;
                            ctl_d.bitcnt = '0;
                            ctl_d.shreg  = ctl_q.wiper;
                            ctl_d.oe     = ~ctl_q.wiper[WORD_W-1];
                        end else begin
                            ctl_d.phase = PH_WAIT;
                            ctl_d.oe    = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q           <= '0;
            ctl_q.phase     <= PH_IDLE;
            ctl_q.kind      <= BY_ID;
            ctl_q.next_kind <= BY_ID;
            ctl_q.after     <= AF_END;
            ctl_q.wiper     <= RESET_CODE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe_o = ctl_q.oe;
    assign wiper_o  = ctl_q.wiper;
    assign upd_o    = ctl_q.upd;
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave #(
    parameter logic [6:0] DEV_ID      = 7'b0101000,
    parameter logic [7:0] REG_ADDR    = 8'h00,
    parameter logic [7:0] RESET_CODE  = 8'h80,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic [7:0] wiper_o,
    output logic       wiper_upd_o
);
    logic scl_s, sda_s;
    logic start_det, stop_det, scl_rise, scl_fall;

    wip_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s)
    );

    wip_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
    );

    wip_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n),
        .scl_s(scl_s), .sda_s(sda_s),
        .start_o(start_det), .stop_o(stop_det),
        .rise_o(scl_rise), .fall_o(scl_fall)
    );

    wip_proto #(
        .DEV_ID(DEV_ID), .REG_ADDR(REG_ADDR), .RESET_CODE(RESET_CODE)
    ) u_proto (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_det), .stop_i(stop_det),
        .rise_i(scl_rise), .fall_i(scl_fall),
        .sda_i(sda_s),
        .sda_oe_o(sda_oe_o), .wiper_o(wiper_o), .upd_o(wiper_upd_o)
    );
endmodule

// File: rtl/wiper_i2c_slave_chk.sv
module wiper_i2c_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       stop_det,
    input logic       sda_oe,
    input logic [7:0] wiper,
    input logic       upd
);
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);

    assert_commit_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> $past(!scl_s));

    assert_wiper_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |-> $stable(wiper));

    assert_stop_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    assert_oe_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(!scl_s));
endmodule

bind wiper_i2c_slave wiper_i2c_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
    .sda_oe(sda_oe_o), .wiper(wiper_o), .upd(wiper_upd_o)
);

// File: tb/wiper_i2c_slave_tb_top.sv
module wiper_i2c_slave_tb_top;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe_o;
    logic [7:0] wiper_o;
    logic       wiper_upd_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe_o;

    wiper_i2c_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe_o), .wiper_o(wiper_o), .wiper_upd_o(wiper_upd_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; half();
        scl_m = 1'b1; half();
        s = sda_line;
        scl_m = 1'b0; half();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1; half();
    endtask

    task automatic write_byte(input logic [7:0] v, input logic chk_commit,
                              input logic [7:0] expw, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        if (chk_commit) chk("R3 commit before ack clock", wiper_o, expw);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(~mack, s);
    endtask

    task automatic do_write(input logic [7:0] d);
        logic a;
        exp_q.push_back(d);
        bus_start();
        write_byte(8'h50, 1'b0, 8'h00, a); chk("R2 id ack", a, 1);
        write_byte(8'h00, 1'b0, 8'h00, a); chk("R2 addr ack", a, 1);
        write_byte(d, 1'b1, d, a);         chk("R2 data ack", a, 1);
        bus_stop();
        chk("R2 wiper after write", wiper_o, d);
    endtask

    task automatic read_setup(output logic ok);
        logic a1, a2, a3;
        bus_start();
        write_byte(8'h50, 1'b0, 8'h00, a1);
        write_byte(8'h00, 1'b0, 8'h00, a2);
        bus_start();
        write_byte(8'h51, 1'b0, 8'h00, a3);
        ok = a1 & a2 & a3;
    endtask

    // scoreboard monitor: compares each commit strobe against the queue
    initial begin
        logic prev_upd;
        prev_upd = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && wiper_upd_o) begin
                if (prev_upd) chk("R2 strobe width", 2, 1);
                if (exp_q.size() == 0) chk("R2 unexpected commit", {24'h0, wiper_o}, 32'hffff_ffff);
                else chk("R2 committed code", wiper_o, exp_q.pop_front());
            end
            prev_upd = rst_n & wiper_upd_o;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic       a, ok, s;
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset code", wiper_o, 8'h80);
        chk("R1 sda released", sda_oe_o, 0);
        chk("R1 no strobe", wiper_upd_o, 0);

        // R9: clocking without START
        scl_m = 1'b0; half();
        write_byte(8'h50, 1'b0, 8'h00, a); chk("R9 no ack without start", a, 0);
        write_byte(8'h00, 1'b0, 8'h00, a); chk("R9 no ack addr", a, 0);
        write_byte(8'h33, 1'b0, 8'h00, a); chk("R9 no ack data", a, 0);
        bus_stop();
        chk("R9 wiper unchanged", wiper_o, 8'h80);

        do_write(8'h3C);

        // R4: wrong identifier
        bus_start();
        write_byte(8'h52, 1'b0, 8'h00, a); chk("R4 bad id nack", a, 0);
        write_byte(8'h00, 1'b0, 8'h00, a); chk("R4 follow nack", a, 0);
        write_byte(8'h77, 1'b0, 8'h00, a); chk("R4 data nack", a, 0);
        bus_stop();
        chk("R4 wiper unchanged", wiper_o, 8'h3C);

        // R5: wrong address
        bus_start();
        write_byte(8'h50, 1'b0, 8'h00, a); chk("R5 id ack", a, 1);
        write_byte(8'h01, 1'b0, 8'h00, a); chk("R5 bad addr nack", a, 0);
        write_byte(8'h99, 1'b0, 8'h00, a); chk("R5 data nack", a, 0);
        bus_stop();
        chk("R5 wiper unchanged", wiper_o, 8'h3C);

        // R6: single read
        read_setup(ok); chk("R6 three acks", ok, 1);
        read_byte(1'b0, v); chk("R6 read data", v, 8'h3C);
        bus_stop();
        chk("R7 released after stop", sda_oe_o, 0);

        // R7: continuous read
        do_write(8'hA5);
        read_setup(ok); chk("R7 three acks", ok, 1);
        read_byte(1'b1, v); chk("R7 byte 1", v, 8'hA5);
        read_byte(1'b1, v); chk("R7 byte 2", v, 8'hA5);
        read_byte(1'b0, v); chk("R7 byte 3", v, 8'hA5);
        bus_stop();
        chk("R7 released after nack stop", sda_oe_o, 0);

        // R8: read id without address
        bus_start();
        write_byte(8'h51, 1'b0, 8'h00, a); chk("R8 read id nack", a, 0);
        clk_bit(1'b1, s); chk("R8 line released", s, 1);
        bus_stop();

        // R11: STOP inside data byte
        bus_start();
        write_byte(8'h50, 1'b0, 8'h00, a); chk("R11 id ack", a, 1);
        write_byte(8'h00, 1'b0, 8'h00, a); chk("R11 addr ack", a, 1);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
        bus_stop();
        chk("R11 no commit", wiper_o, 8'hA5);

        do_write(8'hFF);
        do_write(8'h00);
        read_setup(ok); chk("R6 acks after zero write", ok, 1);
        read_byte(1'b0, v); chk("R6 read zero", v, 8'h00);
        bus_stop();

        repeat (10) @(negedge clk);
        chk("R2 queue drained", exp_q.size(), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule